// File: doc/BRIEF.md
# Synthesiser Control Port over I2C

This block is the serial control slave of a frequency synthesiser. It listens on a two-wire I2C bus (SCL and SDA already brought into the system clock domain) and answers to a 7-bit device address. Five of the address bits are fixed by a parameter and two come from a pair of select inputs, so several synthesisers can share one bus. A write transaction carries data bytes in pairs. The top bit of the first byte of each pair says which pair it is: a divider pair that sets a 15-bit division word, or a control pair that sets the reference ratio, pump current, test mode, path select, oscillator select, reference-output enable and a general port bit.

The division word is built from two bytes but moves to the output only as a whole. It changes once the low byte arrives, or when a stop ends the transaction after only the high byte. This keeps a fine-tuning step from producing a transient mix of old and new bits. A read transaction returns a status byte holding a power-on flag and a lock flag. The status byte repeats for as long as the master acknowledges it. A missing acknowledge makes the slave let go of the bus.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper seven bits equal {ADDR_HI, addr_sel}. Bit 0 of the address byte selects read (1) or write (0). After a non-matching address it drives nothing and changes no output until the next start.
- R2: In a write transaction every complete data byte is acknowledged.
- R3: A first-of-pair byte with bit 7 = 0 is a divider high byte: its bits 6..0 become div_word[14:8]. The next byte becomes div_word[7:0].
- R4: A first-of-pair byte with bit 7 = 1 is control byte A: bits 4..0 are ref_ratio and bits 6..5 are pump_cur. The next byte is control byte B: bits 7..5 test_mode, bit 4 path_sel, bit 3 osc_sel, bit 2 refout_en, bit 1 port_out, bit 0 unused.
- R5: Pairs may follow one another in one transaction without a new address, each classified by the same rule.
- R6: div_word does not change after the high byte alone. On a stop with a high byte pending, div_word[14:8] takes the pending bits and div_word[7:0] keeps its value.
- R7: A stop inside a byte discards that partial byte, and all earlier settings stay.
- R8: A read returns the status byte {por_flag, lock, 6'b0} (bit 7 = power-on flag, bit 6 = lock). It sends the status byte again after each byte the master acknowledges.
- R9: When the master does not acknowledge a status byte, the slave drives SDA no more until the next start.
- R10: The power-on flag is 1 after reset and is cleared by a stop that ends a read transaction addressed to this slave.
- R11: After reset: div_word, ref_ratio, pump_cur, test_mode, path_sel, osc_sel and port_out are 0, and refout_en is 1.
- R12: A repeated start resets pair decoding, so the next data byte is classified again by its bit 7.
- R13: sda_oe changes only while SCL is low, except when a start or stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| scl_i | input | 1 | Sampled bus clock |
| sda_i | input | 1 | Sampled bus data (wired-AND level) |
| addr_sel | input | 2 | Low address bits chosen at board level |
| lock_i | input | 1 | Synthesiser lock indication |
| sda_oe | output | 1 | 1 pulls SDA low |
| div_word | output | 15 | Programmable divider ratio |
| ref_ratio | output | 5 | Reference divider ratio code |
| pump_cur | output | 2 | Charge pump current code |
| test_mode | output | 3 | Test mode code |
| path_sel | output | 1 | Baseband path select |
| osc_sel | output | 1 | Oscillator select |
| refout_en | output | 1 | Buffered reference output enable |
| port_out | output | 1 | General purpose port state |

## Verification
The bench goes after the division-word commit points. A design that committed on every byte would show the new high byte with the old low byte after the first byte of a pair. A design that dropped a pending high byte at a stop would leave the word unchanged. A stop after three bits of a byte checks that partial data never reaches a register. A repeated start between a divider high byte and a control byte catches a decoder that keeps its pair position and would write the control byte into the low divider bits. On the read side, a master NACK followed by more clocks shows whether the slave keeps driving. Reading twice around a stop shows that the power-on flag clears only after a completed read.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
   localparam int BYTE_W    = 8;
   localparam int DIV_W     = 15;
   localparam int DIV_HI_W  = DIV_W - BYTE_W;
   localparam int RATIO_W   = 5;
   localparam int CP_W      = 2;
   localparam int TEST_W    = 3;
   localparam int CNT_W     = $clog2(BYTE_W + 1);
   localparam int STAT_POR  = 7;
   localparam int STAT_LOCK = 6;

   typedef struct packed {
      logic [RATIO_W-1:0] ratio;
      logic [CP_W-1:0]    cp;
      logic [TEST_W-1:0]  test;
      logic               path;
      logic               osc;
      logic               refout;
      logic               port;
   } ctl_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_st_e;
endpackage

// File: rtl/syc_bus_engine.sv
module syc_bus_engine
   import synth_ctl_pkg::*;
#(
   parameter int                  ADDR_HI_W = 5,
   parameter int                  SEL_W     = 2,
   parameter logic [ADDR_HI_W-1:0] ADDR_HI  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  addr_sel,
   input  logic [BYTE_W-1:0] status_i,
   output logic              sda_oe,
   output logic              byte_p,
   output logic [BYTE_W-1:0] byte_o,
   output logic              start_p,
   output logic              stop_p,
   output logic              rd_end_p
);
   localparam int ADDR_W = ADDR_HI_W + SEL_W;

   bus_st_e            st;
   logic               scl_q, sda_q;
   logic [CNT_W-1:0]   bitcnt;
   logic [BYTE_W-1:0]  shreg;
   logic               is_addr, rd_mode, our_read, acked, drive;
   logic [ADDR_W-1:0]  dev_addr;

   assign dev_addr = {ADDR_HI, addr_sel};

   wire scl_rise  = scl_i & ~scl_q;
   wire scl_fall  = ~scl_i & scl_q;
   wire start_det = scl_i & scl_q & sda_q & ~sda_i;
   wire stop_det  = scl_i & scl_q & ~sda_q & sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         bitcnt   <= '0;
         shreg    <= '0;
         is_addr  <= 1'b0;
         rd_mode  <= 1'b0;
         our_read <= 1'b0;
         acked    <= 1'b0;
         drive    <= 1'b0;
         byte_p   <= 1'b0;
         start_p  <= 1'b0;
         stop_p   <= 1'b0;
         rd_end_p <= 1'b0;
      end else begin
         scl_q    <= scl_i;
         sda_q    <= sda_i;
         byte_p   <= 1'b0;
         start_p  <= 1'b0;
         stop_p   <= 1'b0;
         rd_end_p <= 1'b0;
         if (start_det) begin
            st       <= ST_RX;
            bitcnt   <= '0;
            is_addr  <= 1'b1;
            drive    <= 1'b0;
            our_read <= 1'b0;
            start_p  <= 1'b1;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            drive    <= 1'b0;
            stop_p   <= 1'b1;
            rd_end_p <= our_read;
            our_read <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_i};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                     bitcnt <= '0;
                     if (is_addr) begin
                        if (shreg[BYTE_W-1:1] == dev_addr) begin
                           drive    <= 1'b1;
                           rd_mode  <= shreg[0];
                           our_read <= shreg[0];
                           st       <= ST_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        byte_p <= 1'b1;
                        drive  <= 1'b1;
                        st     <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     is_addr <= 1'b0;
                     if (rd_mode) begin
                        shreg  <= {status_i[BYTE_W-2:0], 1'b0};
                        drive  <= ~status_i[BYTE_W-1];
                        bitcnt <= CNT_W'(1);
                        st     <= ST_TX;
                     end else begin
                        drive <= 1'b0;
                        st    <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == CNT_W'(BYTE_W)) begin
                        drive <= 1'b0;
                        acked <= 1'b0;
                        st    <= ST_MACK;
                     end else begin
                        drive  <= ~shreg[BYTE_W-1];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     if (sda_i) st <= ST_IDLE;
                     else       acked <= 1'b1;
                  end else if (scl_fall && acked) begin
                     shreg  <= {status_i[BYTE_W-2:0], 1'b0};
                     drive  <= ~status_i[BYTE_W-1];
                     bitcnt <= CNT_W'(1);
                     st     <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = drive;
   assign byte_o = shreg;

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (drive != $past(drive)) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_i)); // R13

   AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st == ST_MACK) && $past(scl_rise) && $past(sda_i) && !$past(start_det) && !$past(stop_det)
      |-> !drive); // R9

   AST_TX_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX) |-> our_read); // R8

   AST_BYTE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      byte_p |-> !our_read && drive); // R2
endmodule

// File: rtl/syc_pair_decoder.sv
module syc_pair_decoder
   import synth_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_p,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              start_p,
   input  logic              stop_p,
   output logic [DIV_W-1:0]  div_o,
   output ctl_t              ctl_o
);
   logic                second, second_ctl, pend_v;
   logic [DIV_HI_W-1:0] pend_hi;
   wire                 unused_ok = byte_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second     <= 1'b0;
         second_ctl <= 1'b0;
         pend_v     <= 1'b0;
         pend_hi    <= '0;
         div_o      <= '0;
         ctl_o      <= '{ratio: '0, cp: '0, test: '0, path: 1'b0,
                         osc: 1'b0, refout: 1'b1, port: 1'b0};
      end else if (start_p || stop_p) begin
         second <= 1'b0;
         if (stop_p && pend_v) begin
            div_o[DIV_W-1:BYTE_W] <= pend_hi;
            pend_v                <= 1'b0;
         end
      end else if (byte_p) begin
         if (!second) begin
            second     <= 1'b1;
            second_ctl <= byte_i[BYTE_W-1];
            if (byte_i[BYTE_W-1]) begin
               ctl_o.ratio <= byte_i[RATIO_W-1:0];
               ctl_o.cp    <= byte_i[RATIO_W+CP_W-1:RATIO_W];
            end else begin
               pend_hi <= byte_i[DIV_HI_W-1:0];
               pend_v  <= 1'b1;
            end
         end else begin
            second <= 1'b0;
            if (second_ctl) begin
               ctl_o.test   <= byte_i[7:5];
               ctl_o.path   <= byte_i[4];
               ctl_o.osc    <= byte_i[3];
               ctl_o.refout <= byte_i[2];
               ctl_o.port   <= byte_i[1];
            end else begin
               div_o  <= {pend_hi, byte_i};
               pend_v <= 1'b0;
            end
         end
      end
   end

   AST_DIV_COMMIT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      (div_o != $past(div_o)) |-> $past(stop_p) || ($past(byte_p) && $past(second))); // R6

   AST_CTL_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o.ratio != $past(ctl_o.ratio)) |-> $past(byte_p) && !$past(second)
                                             && $past(byte_i[BYTE_W-1])); // R4
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
   import synth_ctl_pkg::*;
#(
   parameter int                   ADDR_HI_W  = 5,
   parameter logic [ADDR_HI_W-1:0] ADDR_HI    = 5'b11000,
   parameter int                   LOCK_SYNC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [1:0]         addr_sel,
   input  logic               lock_i,
   output logic               sda_oe,
   output logic [DIV_W-1:0]   div_word,
   output logic [RATIO_W-1:0] ref_ratio,
   output logic [CP_W-1:0]    pump_cur,
   output logic [TEST_W-1:0]  test_mode,
   output logic               path_sel,
   output logic               osc_sel,
   output logic               refout_en,
   output logic               port_out
);
   localparam int SEL_W = 2;

   if (ADDR_HI_W + SEL_W != 7) begin : g_bad_addr
      $error("address must total seven bits");
   end
   if (LOCK_SYNC < 0 || LOCK_SYNC > 4) begin : g_bad_sync
      $error("LOCK_SYNC out of range");
   end

   logic              lock_s, por_flag;
   logic              byte_p, start_p, stop_p, rd_end_p;
   logic [BYTE_W-1:0] byte_d, status;
   ctl_t              ctl;

   if (LOCK_SYNC == 0) begin : g_lock_direct
      assign lock_s = lock_i;
   end else begin : g_lock_sync
      logic [LOCK_SYNC-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[LOCK_SYNC-2 >= 0 ? LOCK_SYNC-2 : 0 : 0], lock_i} & {LOCK_SYNC{1'b1}};
      end
      assign lock_s = chain[LOCK_SYNC-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        por_flag <= 1'b1;
      else if (rd_end_p) por_flag <= 1'b0;
   end

   always_comb begin
      status            = '0;
      status[STAT_POR]  = por_flag;
      status[STAT_LOCK] = lock_s;
   end

   syc_bus_engine #(
      .ADDR_HI_W(ADDR_HI_W),
      .SEL_W    (SEL_W),
      .ADDR_HI  (ADDR_HI)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .addr_sel(addr_sel),
      .status_i(status),
      .sda_oe  (sda_oe),
      .byte_p  (byte_p),
      .byte_o  (byte_d),
      .start_p (start_p),
      .stop_p  (stop_p),
      .rd_end_p(rd_end_p)
   );

   syc_pair_decoder u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_p (byte_p),
      .byte_i (byte_d),
      .start_p(start_p),
      .stop_p (stop_p),
      .div_o  (div_word),
      .ctl_o  (ctl)
   );

   assign ref_ratio = ctl.ratio;
   assign pump_cur  = ctl.cp;
   assign test_mode = ctl.test;
   assign path_sel  = ctl.path;
   assign osc_sel   = ctl.osc;
   assign refout_en = ctl.refout;
   assign port_out  = ctl.port;

   AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(por_flag) |-> $past(rd_end_p)); // R10

   AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(por_flag) |-> !por_flag); // R10
endmodule

// File: tb/synth_ctl_i2c_tb.sv
module synth_ctl_i2c_tb;
   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [1:0]  addr_sel = 2'b10;
   logic        lock_i = 1'b1;
   logic        sda_oe;
   logic [14:0] div_word;
   logic [4:0]  ref_ratio;
   logic [1:0]  pump_cur;
   logic [2:0]  test_mode;
   logic        path_sel, osc_sel, refout_en, port_out;
   logic        sda_line;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   assign sda_line = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   synth_ctl_i2c u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .addr_sel (addr_sel),
      .lock_i   (lock_i),
      .sda_oe   (sda_oe),
      .div_word (div_word),
      .ref_ratio(ref_ratio),
      .pump_cur (pump_cur),
      .test_mode(test_mode),
      .path_sel (path_sel),
      .osc_sel  (osc_sel),
      .refout_en(refout_en),
      .port_out (port_out)
   );

   localparam logic [7:0] AW = 8'hC4;
   localparam logic [7:0] AR = 8'hC5;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic half();
      repeat (HP) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      sda_m = 1'b0; half();
      scl_m = 1'b0; half();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; half();
      scl_m = 1'b1; half();
      sda_m = 1'b1; half();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      ack = ~sda_line;
      scl_m = 1'b0;
   endtask

   task automatic get_byte(input logic mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; half();
         scl_m = 1'b1; half();
         d[i] = sda_line;
         scl_m = 1'b0;
      end
      sda_m = ~mack; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
      half();
      sda_m = 1'b1;
   endtask

   task automatic t_reset();
      chk("R11 div", 32'(div_word), 0);
      chk("R11 ctl", {ref_ratio, pump_cur, test_mode, path_sel, osc_sel, port_out}, 0);
      chk("R11 refout", 32'(refout_en), 1);
      chk("R13 idle oe", 32'(sda_oe), 0);
   endtask

   task automatic t_freq();
      logic a;
      i2c_start();
      send_byte(AW, a);   chk("R1 addr ack", 32'(a), 1);
      send_byte(8'h12, a); chk("R2 data ack", 32'(a), 1);
      half();
      chk("R6 hold after hi", 32'(div_word), 0);
      send_byte(8'h34, a);
      half();
      chk("R3 div word", 32'(div_word), 32'h1234);
      i2c_stop();
   endtask

   task automatic t_ctl();
      logic a;
      i2c_start();
      send_byte(AW, a);
      send_byte(8'hCB, a);
      send_byte(8'hB2, a);
      i2c_stop();
      chk("R4 ratio/cp", {ref_ratio, pump_cur}, {5'h0B, 2'd2});
      chk("R4 byteB", {test_mode, path_sel, osc_sel, refout_en, port_out}, {3'd5, 4'b1001});
      chk("R4 div kept", 32'(div_word), 32'h1234);
   endtask

   task automatic t_multi();
      logic a;
      i2c_start();
      send_byte(AW, a);
      send_byte(8'h05, a); send_byte(8'h67, a);
      half();
      chk("R5 first pair", 32'(div_word), 32'h0567);
      send_byte(8'h81, a); send_byte(8'h00, a);
      send_byte(8'h7F, a); send_byte(8'hFF, a);
      i2c_stop();
      chk("R5 last pair", 32'(div_word), 32'h7FFF);
      chk("R5 ctl pair", {ref_ratio, pump_cur, refout_en}, {5'h01, 2'd0, 1'b0});
   endtask

   task automatic t_stop_hi();
      logic a;
      i2c_start();
      send_byte(AW, a);
      send_byte(8'h2A, a);
      half();
      chk("R6 no change yet", 32'(div_word), 32'h7FFF);
      i2c_stop();
      chk("R6 stop commit", 32'(div_word), 32'h2AFF);
   endtask

   task automatic t_partial();
      logic a;
      i2c_start();
      send_byte(AW, a);
      send_byte(8'h11, a); send_byte(8'h22, a);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      i2c_stop();
      chk("R7 div kept", 32'(div_word), 32'h1122);
      chk("R7 ctl kept", {ref_ratio, pump_cur}, {5'h01, 2'd0});
   endtask

   task automatic t_rstart();
      logic a;
      i2c_start();
      send_byte(AW, a);
      send_byte(8'h03, a);
      i2c_start();
      send_byte(AW, a);
      send_byte(8'h85, a);
      send_byte(8'h04, a);
      half();
      chk("R12 reclassify", 32'(ref_ratio), 5);
      chk("R12 byteB", {test_mode, refout_en}, {3'd0, 1'b1});
      i2c_stop();
      chk("R6 pending at stop", 32'(div_word), 32'h0322);
   endtask

   task automatic t_badaddr();
      logic a;
      i2c_start();
      send_byte(8'hC6, a); chk("R1 no ack", 32'(a), 0);
      send_byte(8'h01, a); chk("R1 data ignored ack", 32'(a), 0);
      send_byte(8'h02, a);
      i2c_stop();
      chk("R1 div unchanged", 32'(div_word), 32'h0322);
   endtask

   task automatic t_read();
      logic a;
      logic [7:0] d;
      i2c_start();
      send_byte(AR, a);  chk("R1 read ack", 32'(a), 1);
      get_byte(1'b1, d); chk("R8 status por+lock", 32'(d), 32'hC0);
      get_byte(1'b0, d); chk("R8 repeat status", 32'(d), 32'hC0);
      get_byte(1'b1, d); chk("R9 released", 32'(d), 32'hFF);
      chk("R9 oe low", 32'(sda_oe), 0);
      i2c_stop();
      lock_i = 1'b0;
      half();
      i2c_start();
      send_byte(AR, a);
      get_byte(1'b0, d); chk("R10 por cleared", 32'(d), 32'h00);
      i2c_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_freq();
      t_ctl();
      t_multi();
      t_stop_hi();
      t_partial();
      t_rstart();
      t_badaddr();
      t_read();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule